// File: doc/BRIEF.md
# Activate Spacing and Window Gate

This block sits inside a DRAM command scheduler and decides, on each clock, whether a pending row-activate request may go out. It enforces three independent limits. The first is a minimum gap between any two activates, whatever the bank. The second is a rolling cap of four activates within a fixed span of cycles. The third is a per-bank row-cycle time, measured from that bank's previous activate. The gap and the rolling span both depend on a page-size select input. Each limit is fixed at elaboration: a nanosecond figure is divided by the clock period and rounded up.

The scheduler holds `req_i` together with a bank number. The gate answers in the same cycle. It raises `grant_o` when every limit is satisfied and `stall_o` when at least one is not. A request that is held is granted on the first cycle that all limits clear. The per-bank ready flags let the scheduler choose a bank that will not be blocked by its own row-cycle time. The rolling cap can be removed by parameter for parts with few banks; the gap and row-cycle limits then remain.

Top module: `act_gate`

## Requirements
- R1: After reset, `grant_o` and `stall_o` are 0 while no request is made, and every bit of `bank_ready_o` is 1.
- R2: `grant_o` is 1 only in a cycle where `req_i` is 1. `stall_o` equals `req_i` and not `grant_o`, so the two outputs are never both 1.
- R3: An activate granted in cycle t blocks every further grant until cycle t+G. G is the larger of 2 and ceil(gap_ps / TCK_PS). With the default parameters G is 3 cycles when `page_big_i`=0 (small page) and 4 cycles when `page_big_i`=1 (large page).
- R4: When `FAW_EN`=1, at most four grants occur in any W consecutive cycles. The fifth grant comes no earlier than the cycle of the fourth-previous grant plus W. W is ceil(window_ps / TCK_PS): 15 cycles for a small page and 20 cycles for a large page with the defaults.
- R5: The gap and window that a grant imposes are set by the value of `page_big_i` in the cycle of that grant. Later changes of the select do not alter them.
- R6: A bank granted in cycle t is not granted again before cycle t+C, where C is ceil(RC_PS / TCK_PS); the default is 22. `bank_ready_o[b]` is 0 from cycle t+1 through t+C-1 and is 1 again in cycle t+C.
- R7: A request held at the inputs is granted in the first cycle in which the R3, R4 and R6 limits are all met, and not later.
- R8: When `FAW_EN`=0, only the R3 and R6 limits apply. Five or more activates may then issue at the minimum gap.
- R9: `bank_ready_o` reflects only the row-cycle limit. A bank whose own limit is met reads 1 even while the gap or window limit is blocking grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Activate request pending this cycle |
| bank_i | input | BANK_W | Bank addressed by the request |
| page_big_i | input | 1 | 0 selects small-page limits, 1 selects large-page limits |
| grant_o | output | 1 | Activate may issue this cycle |
| stall_o | output | 1 | Request present but blocked |
| bank_ready_o | output | NUM_BANKS | Per-bank row-cycle limit met |

## Verification
On every cycle, the bound checker keeps its own grant timestamps. It confirms that no grant breaks the minimum gap, the four-per-window cap or the per-bank row-cycle time. It also confirms that a granted bank was ready, that it turns not-ready on the next cycle, and that grant and stall never overlap. These properties only bound grants from below. That a held request is granted exactly on the earliest legal cycle, with no extra delay, is shown only by the bench. The bench does this by comparing each grant cycle with an arithmetic schedule over sweeps of bank patterns and page sizes. This includes the fifth back-to-back activate waiting three extra cycles on a small page, and the unbounded variant issuing it at the plain gap.

// File: rtl/act_gate_pkg.sv
package act_gate_pkg;

  // Clock count for a time limit: rounded up, never under floor_cyc.
  function automatic int unsigned cyc_of(input int unsigned t_ps,
                                         input int unsigned tck_ps,
                                         input int unsigned floor_cyc);
    int unsigned r;
    r = (t_ps + tck_ps - 1) / tck_ps;
    return (r < floor_cyc) ? floor_cyc : r;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/act_gap_timer.sv
// Saturating down-counter: after fire_i, ok_o drops for LOAD_x cycles.
module act_gap_timer #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned LOAD_A = 3,
  parameter int unsigned LOAD_B = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic sel_i,
  output logic ok_o
);
  localparam logic [CNT_W-1:0] LD_A = CNT_W'(LOAD_A - 1);
  localparam logic [CNT_W-1:0] LD_B = CNT_W'(LOAD_B - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (fire_i)      cnt_q <= sel_i ? LD_B : LD_A;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign ok_o = (cnt_q == '0);
endmodule

// File: rtl/act_window_track.sv
// Holds the remaining window time of the last DEPTH grants; oldest must be 0.
module act_window_track #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned LOAD_A = 15,
  parameter int unsigned LOAD_B = 20,
  parameter bit          ENABLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic sel_i,
  output logic ok_o
);
  localparam logic [CNT_W-1:0] LD_A = CNT_W'(LOAD_A - 1);
  localparam logic [CNT_W-1:0] LD_B = CNT_W'(LOAD_B - 1);

  if (ENABLE) begin : g_win
    logic [CNT_W-1:0] slot_q [DEPTH];

    function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
      return (v == '0) ? v : v - 1'b1;
    endfunction

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else if (fire_i) begin
        slot_q[0] <= sel_i ? LD_B : LD_A;
        for (int i = 1; i < DEPTH; i++) slot_q[i] <= dec(slot_q[i-1]);
      end else begin
        for (int i = 0; i < DEPTH; i++) slot_q[i] <= dec(slot_q[i]);
      end
    end

    assign ok_o = (slot_q[DEPTH-1] == '0);
  end else begin : g_nowin
    logic unused_win;
    assign unused_win = ^{clk_i, rst_ni, fire_i, sel_i};
    assign ok_o = 1'b1;
  end
endmodule

// File: rtl/act_bank_timers.sv
module act_bank_timers #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned RC_CYC    = 22
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fire_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic [NUM_BANKS-1:0] ready_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = fire_i && (bank_i == BANK_W'(b));
    act_gap_timer #(.CNT_W(CNT_W), .LOAD_A(RC_CYC), .LOAD_B(RC_CYC)) u_rc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .fire_i(hit),
      .sel_i (1'b0),
      .ok_o  (ready_o[b])
    );
  end
endmodule

// File: rtl/act_gate.sv
module act_gate
  import act_gate_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned TCK_PS      = 2500,
  parameter int unsigned GAP_SM_PS   = 7500,
  parameter int unsigned GAP_LG_PS   = 10000,
  parameter int unsigned WIN_SM_PS   = 37500,
  parameter int unsigned WIN_LG_PS   = 50000,
  parameter int unsigned RC_PS       = 55000,
  parameter bit          FAW_EN      = 1'b1,
  localparam int unsigned BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 page_big_i,
  output logic                 grant_o,
  output logic                 stall_o,
  output logic [NUM_BANKS-1:0] bank_ready_o
);
  localparam int unsigned GAP_SM = cyc_of(GAP_SM_PS, TCK_PS, 2);
  localparam int unsigned GAP_LG = cyc_of(GAP_LG_PS, TCK_PS, 2);
  localparam int unsigned WIN_SM = cyc_of(WIN_SM_PS, TCK_PS, 1);
  localparam int unsigned WIN_LG = cyc_of(WIN_LG_PS, TCK_PS, 1);
  localparam int unsigned RC_CYC = cyc_of(RC_PS, TCK_PS, 2);
  localparam int unsigned GAP_W  = $clog2(max2(GAP_SM, GAP_LG) + 1);
  localparam int unsigned WIN_W  = $clog2(max2(WIN_SM, WIN_LG) + 1);
  localparam int unsigned RC_W   = $clog2(RC_CYC + 1);
  localparam int unsigned WIN_DEPTH = 4;

  logic gap_ok, win_ok, bank_ok;

  act_gap_timer #(.CNT_W(GAP_W), .LOAD_A(GAP_SM), .LOAD_B(GAP_LG)) u_gap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(grant_o),
    .sel_i (page_big_i),
    .ok_o  (gap_ok)
  );

  act_window_track #(
    .DEPTH (WIN_DEPTH),
    .CNT_W (WIN_W),
    .LOAD_A(WIN_SM),
    .LOAD_B(WIN_LG),
    .ENABLE(FAW_EN)
  ) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(grant_o),
    .sel_i (page_big_i),
    .ok_o  (win_ok)
  );

  act_bank_timers #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .CNT_W    (RC_W),
    .RC_CYC   (RC_CYC)
  ) u_banks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (grant_o),
    .bank_i (bank_i),
    .ready_o(bank_ready_o)
  );

  assign bank_ok = bank_ready_o[bank_i];
  assign grant_o = req_i && gap_ok && win_ok && bank_ok;
  assign stall_o = req_i && !grant_o;
endmodule

// File: rtl/act_gate_chk.sv
module act_gate_chk
  import act_gate_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned TCK_PS    = 2500,
  parameter int unsigned GAP_SM_PS = 7500,
  parameter int unsigned GAP_LG_PS = 10000,
  parameter int unsigned WIN_SM_PS = 37500,
  parameter int unsigned WIN_LG_PS = 50000,
  parameter int unsigned RC_PS     = 55000,
  parameter bit          FAW_EN    = 1'b1,
  parameter int unsigned BANK_W    = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic [BANK_W-1:0]    bank_i,
  input logic                 page_big_i,
  input logic                 grant_o,
  input logic                 stall_o,
  input logic [NUM_BANKS-1:0] bank_ready_o
);
  localparam int unsigned GAP_SM = cyc_of(GAP_SM_PS, TCK_PS, 2);
  localparam int unsigned GAP_LG = cyc_of(GAP_LG_PS, TCK_PS, 2);
  localparam int unsigned WIN_SM = cyc_of(WIN_SM_PS, TCK_PS, 1);
  localparam int unsigned WIN_LG = cyc_of(WIN_LG_PS, TCK_PS, 1);

  logic [31:0] now_q, gap_exp_q;
  logic [31:0] win_exp_q [4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q     <= '0;
      gap_exp_q <= '0;
      for (int i = 0; i < 4; i++) win_exp_q[i] <= '0;
    end else begin
      now_q <= now_q + 1;
      if (grant_o) begin
        gap_exp_q    <= now_q + (page_big_i ? GAP_LG : GAP_SM);
        win_exp_q[0] <= now_q + (page_big_i ? WIN_LG : WIN_SM);
        for (int i = 1; i < 4; i++) win_exp_q[i] <= win_exp_q[i-1];
      end
    end
  end

  assert_grant_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> req_i);
  assert_grant_stall_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && stall_o));
  assert_gap_met_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (now_q >= gap_exp_q));
  assert_no_adjacent_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o);
  assert_bank_was_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> bank_ready_o[bank_i]);
  assert_bank_busy_after_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !bank_ready_o[$past(bank_i)]);

  if (FAW_EN) begin : g_win_chk
    assert_window_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o |-> (now_q >= win_exp_q[3]));
  end
endmodule

bind act_gate act_gate_chk #(
  .NUM_BANKS(NUM_BANKS),
  .TCK_PS   (TCK_PS),
  .GAP_SM_PS(GAP_SM_PS),
  .GAP_LG_PS(GAP_LG_PS),
  .WIN_SM_PS(WIN_SM_PS),
  .WIN_LG_PS(WIN_LG_PS),
  .RC_PS    (RC_PS),
  .FAW_EN   (FAW_EN),
  .BANK_W   (BANK_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .bank_i      (bank_i),
  .page_big_i  (page_big_i),
  .grant_o     (grant_o),
  .stall_o     (stall_o),
  .bank_ready_o(bank_ready_o)
);

// File: tb/act_gate_test.sv
`timescale 1ns/1ps
module act_gate_test;
  // Expected cycle counts, from the requirements with default timing.
  localparam int GAP_SM = 3, GAP_LG = 4, WIN_SM = 15, WIN_LG = 20;
  localparam int RC_MAIN = 22, RC_NF = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0;
  logic [2:0] bank = '0;
  logic page_big = 1'b0;
  logic grant, stall, nf_grant, nf_stall;
  logic [7:0] ready;
  logic [3:0] nf_ready;
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  act_gate uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .bank_i(bank),
    .page_big_i(page_big), .grant_o(grant), .stall_o(stall), .bank_ready_o(ready)
  );

  act_gate #(.NUM_BANKS(4), .RC_PS(20000), .FAW_EN(1'b0)) uut_nf (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .bank_i(bank[1:0]),
    .page_big_i(page_big), .grant_o(nf_grant), .stall_o(nf_stall), .bank_ready_o(nf_ready)
  );

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 1'b0;
    end
  endtask

  function automatic int bank_of(input int mode, input int k);
    case (mode)
      0: return k % 8;
      1: return 5;
      2: return k % 2;
      default: return k % 4;
    endcase
  endfunction

  // Holds each request until granted; compares grant cycle with the schedule.
  task automatic run_seq(input bit use_nf, input int mode, input bit big,
                         input bit big_first, input int n, input string tag);
    int exp_t[16];
    bit pg[16];
    int cyc, got, e, rc;
    bit g;
    rc = use_nf ? RC_NF : RC_MAIN;
    idle(60);
    cyc = 0;
    for (int k = 0; k < n; k++) begin
      pg[k] = big_first ? (k == 0) : big;
      e = 0;
      if (k > 0) e = exp_t[k-1] + (pg[k-1] ? GAP_LG : GAP_SM);
      if (!use_nf && k >= 4 && exp_t[k-4] + (pg[k-4] ? WIN_LG : WIN_SM) > e)
        e = exp_t[k-4] + (pg[k-4] ? WIN_LG : WIN_SM);
      for (int j = 0; j < k; j++)
        if (bank_of(mode, j) == bank_of(mode, k) && exp_t[j] + rc > e) e = exp_t[j] + rc;
      exp_t[k] = e;
      got = -1;
      while (got < 0 && cyc < 300) begin
        @(negedge clk);
        req = 1'b1;
        bank = 3'(bank_of(mode, k));
        page_big = pg[k];
        #1;
        g = use_nf ? nf_grant : grant;
        if (!use_nf && !g) check(stall == 1'b1, {tag, " R2 stall"}, int'(stall), 1);
        if (g) got = cyc;
        cyc++;
      end
      check(got == e, tag, got, e);
    end
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(grant == 1'b0, "R1 grant", int'(grant), 0);
    check(stall == 1'b0, "R1 stall", int'(stall), 0);
    check(ready == 8'hff, "R1 ready", int'(ready), 255);
    @(negedge clk);
    rst_ni = 1'b1;
    idle(2);
    #1;
    check(ready == 8'hff && grant == 1'b0, "R1 after release", int'(ready), 255);

    // R3 R4 R7: eight banks back to back, fifth waits for the window
    run_seq(1'b0, 0, 1'b0, 1'b0, 8, "R4 small page sweep");
    run_seq(1'b0, 0, 1'b1, 1'b0, 8, "R3 large page sweep");
    // R6: same bank repeatedly
    run_seq(1'b0, 1, 1'b0, 1'b0, 3, "R6 same bank");
    // R6 R7: two banks alternating
    run_seq(1'b0, 2, 1'b0, 1'b0, 6, "R7 two banks");
    run_seq(1'b0, 3, 1'b1, 1'b0, 12, "R7 four banks large");
    // R5: large-page grant followed by small-page request keeps the large gap
    run_seq(1'b0, 0, 1'b0, 1'b1, 6, "R5 page switch");
    // R8: no window limit, fifth activate at the plain gap
    run_seq(1'b1, 3, 1'b0, 1'b0, 8, "R8 no window");

    // R6 R9: ready flag timing after a single grant to bank 3
    idle(60);
    @(negedge clk);
    req = 1'b1; bank = 3'd3; page_big = 1'b0;
    #1;
    check(grant == 1'b1, "R2 idle grant", int'(grant), 1);
    @(negedge clk);
    req = 1'b1; bank = 3'd4;
    #1;
    check(grant == 1'b0, "R3 blocked", int'(grant), 0);
    check(ready[4] == 1'b1, "R9 ready while gap blocks", int'(ready[4]), 1);
    check(ready[3] == 1'b0, "R6 busy t+1", int'(ready[3]), 0);
    req = 1'b0;
    for (int c = 2; c <= RC_MAIN; c++) begin
      @(negedge clk);
      #1;
      if (c == RC_MAIN - 1) check(ready[3] == 1'b0, "R6 busy t+C-1", int'(ready[3]), 0);
      if (c == RC_MAIN)     check(ready[3] == 1'b1, "R6 ready t+C", int'(ready[3]), 1);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule